// File: doc/BRIEF.md
# Cassette Serial Receiver with Carrier-Loss Interrupt

This block receives asynchronous serial characters from a cassette-style input and hands them to a host through a small register bus. A character is shifted in from the serial line and then moved into a held receive data register. Because the character is held there, the next character can be shifted in while the host has not yet collected the previous one.

A carrier-detect input reports whether a tone is present: low means carrier, high means no carrier. A rise on this input is captured in the status register and stays visible until the host clears it through a status read followed by a data read. The host can poll the status register. It can also set the enable bit in the control register and take an active-low interrupt when a character has arrived or when the carrier has been lost.

The bus uses one register select line. A read with the select low returns status, and a read with it high returns the received character. A write with the select low loads the control register, and a write with it high does nothing. A serial tick input gives 16 pulses per bit period.

Top module: `tape_rx`

## Requirements
- R1: After the synchronous reset, the status register reads 0x00 while the carrier input is low, the control register is 0x00 and `irq_n` is high.
- R2: A frame has one low start bit, 8 data bits sent LSB first and one high stop bit, each lasting 16 ticks of `rx_tick`. Each bit is sampled near its middle. A valid frame loads the character into the data register (read with `rs`=1) and sets status bit 0.
- R3: A frame whose stop bit is sampled low is discarded: the data register and status bit 0 do not change.
- R4: A low pulse on `rxd` shorter than half a bit period is not taken as a start bit, and no character results from it.
- R5: A read of the data register clears status bit 0. It also ends the receive interrupt, unless a new character is loaded in that same cycle.
- R6: While status bit 0 is set, reception continues. The next valid character replaces the held one, and status bit 0 stays set.
- R7: Status bit 2 reads the live value of `dcd` ORed with a carrier-loss latch. The latch is set in the cycle after `dcd` rises.
- R8: The carrier-loss latch is cleared only by a status read made while the latch is set, followed later by a data read. A data read without that earlier status read leaves the latch set.
- R9: `irq_n` is low exactly when control bit 7 is 1 and either status bit 0 or the carrier-loss latch is set. Status bit 7 reads 1 exactly when `irq_n` is low. With control bit 7 at 0, the block works purely by polling and `irq_n` stays high.
- R10: While control bits 1:0 equal 11, status bit 0 and the carrier-loss latch are held clear, the receiver is held idle, and no character is received. Writing any other value in bits 1:0 lets reception resume.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Bus access strobe, one cycle per access |
| rw | input | 1 | 1 = read, 0 = write |
| rs | input | 1 | Register select: 0 = status/control, 1 = data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq_n | output | 1 | Active-low interrupt request |
| rx_tick | input | 1 | Receive sampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial data input, idle high |
| dcd | input | 1 | Carrier detect, high = carrier lost |

## Verification
Random bytes, together with the directed bytes 0x00, 0xFF and 0xA5, are sent as frames. These show whether every data bit lands in its own position with LSB-first order, and whether a character stuck at all-zero or all-one is told apart from one that really carries those values. A frame with a low stop bit and a short false start are sent to check that broken framing produces no character. Two frames sent back to back without a read check that the held character is replaced. A carrier pulse is then followed by data and status reads in several orders, with interrupts first disabled and then enabled. This separates the live carrier value from the latched one and shows which read sequence releases the latch and the interrupt.

// File: rtl/tape_rx_pkg.sv
package tape_rx_pkg;

    localparam int DW         = 8;   // character width
    localparam int OVERSAMPLE = 16;  // ticks per bit period

    localparam logic [1:0] MODE_MRESET = 2'b11;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // control byte: bit 7 interrupt enable, bits 1:0 mode (11 = master reset)
    typedef struct packed {
        logic       rie;
        logic [4:0] rsvd;
        logic [1:0] mode;
    } ctrl_t;

    // status byte: bit 7 irq, bit 2 carrier lost, bit 0 data full
    typedef struct packed {
        logic       irq;
        logic [3:0] zero_hi;
        logic       nocar;
        logic       zero_lo;
        logic       full;
    } status_t;

    function automatic status_t make_status(logic full, logic nocar, logic irq);
        status_t s;
        s         = '0;
        s.full    = full;
        s.nocar   = nocar;
        s.irq     = irq;
        return s;
    endfunction

endpackage

// File: rtl/tape_rx_deser.sv
module tape_rx_deser
    import tape_rx_pkg::*;
#(
    parameter int OVS = OVERSAMPLE,
    parameter int W   = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         tick,
    input  logic         rxd,
    output logic         load,
    output logic [W-1:0] rx_byte
);
    localparam int CW   = $clog2(OVS);
    localparam int BW   = $clog2(W);
    localparam int HALF = OVS / 2 - 1;

    rx_state_e    st;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bidx;
    logic [W-1:0]  shreg;

    wire bit_end = (cnt == CW'(OVS - 1));

    always_ff @(posedge clk) begin
        load <= 1'b0;
        if (rst || hold) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            shreg <= '0;
        end else if (tick) begin
            unique case (st)
                RX_IDLE: begin
                    if (!rxd) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                end
                RX_START: begin
                    if (cnt == CW'(HALF)) begin
                        cnt  <= '0;
                        bidx <= '0;
                        st   <= rxd ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                RX_DATA: begin
                    if (bit_end) begin
                        cnt   <= '0;
                        shreg <= {rxd, shreg[W-1:1]};
                        if (bidx == BW'(W - 1)) st <= RX_STOP;
                        else                    bidx <= bidx + BW'(1);
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                RX_STOP: begin
                    if (bit_end) begin
                        cnt  <= '0;
                        st   <= RX_IDLE;
                        load <= rxd;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    assign rx_byte = shreg;

endmodule

// File: rtl/tape_rx_regs.sv
module tape_rx_regs
    import tape_rx_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_ctrl,
    input  logic         rd_stat,
    input  logic         rd_data,
    input  logic [W-1:0] wdata,
    input  logic         load,
    input  logic [W-1:0] rx_byte,
    input  logic         dcd,
    output ctrl_t        ctrl,
    output logic [W-1:0] data_q,
    output logic         full,
    output logic         lat,
    output logic         arm,
    output logic         irq
);
    logic dcd_q;
    wire  mreset = (ctrl.mode == MODE_MRESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            data_q <= '0;
            full   <= 1'b0;
            lat    <= 1'b0;
            arm    <= 1'b0;
            dcd_q  <= dcd;
        end else begin
            dcd_q <= dcd;
            if (wr_ctrl) ctrl <= ctrl_t'(wdata);
            if (mreset) begin
                full <= 1'b0;
                lat  <= 1'b0;
                arm  <= 1'b0;
            end else begin
                if (load) begin
                    data_q <= rx_byte;
                    full   <= 1'b1;
                end else if (rd_data) begin
                    full <= 1'b0;
                end
                if (dcd && !dcd_q) begin
                    lat <= 1'b1;
                    arm <= 1'b0;
                end else if (rd_data && arm) begin
                    lat <= 1'b0;
                    arm <= 1'b0;
                end else if (rd_stat && lat) begin
                    arm <= 1'b1;
                end
            end
        end
    end

    assign irq = ctrl.rie & (full | lat);

endmodule

// File: rtl/tape_rx.sv
module tape_rx
    import tape_rx_pkg::*;
#(
    parameter int OVS = OVERSAMPLE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs,
    input  logic       rw,
    input  logic       rs,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq_n,
    input  logic       rx_tick,
    input  logic       rxd,
    input  logic       dcd
);
    ctrl_t      ctrl;
    logic       rx_load;
    logic [7:0] rx_byte;
    logic [7:0] data_q;
    logic       rdrf;
    logic       dcd_lat;
    logic       rd_arm;
    logic       irq;
    status_t    stat;

    wire mreset  = (ctrl.mode == MODE_MRESET);
    wire rie     = ctrl.rie;
    wire wr_ctrl = cs & ~rw & ~rs;
    wire rd_stat = cs &  rw & ~rs;
    wire rd_data = cs &  rw &  rs;

    tape_rx_deser #(.OVS(OVS), .W(8)) i_deser (
        .clk     (clk),
        .rst     (rst),
        .hold    (mreset),
        .tick    (rx_tick),
        .rxd     (rxd),
        .load    (rx_load),
        .rx_byte (rx_byte)
    );

    tape_rx_regs #(.W(8)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .rd_stat (rd_stat),
        .rd_data (rd_data),
        .wdata   (wdata),
        .load    (rx_load),
        .rx_byte (rx_byte),
        .dcd     (dcd),
        .ctrl    (ctrl),
        .data_q  (data_q),
        .full    (rdrf),
        .lat     (dcd_lat),
        .arm     (rd_arm),
        .irq     (irq)
    );

    always_comb begin
        stat  = make_status(rdrf, dcd | dcd_lat, irq);
        rdata = rs ? data_q : stat;
    end

    assign irq_n = ~irq;

endmodule

// File: rtl/tape_rx_chk.sv
module tape_rx_chk
    import tape_rx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cs,
    input logic       rw,
    input logic       rs,
    input logic [7:0] wdata,
    input logic       dcd,
    input logic       irq_n,
    input ctrl_t      ctrl,
    input logic       rie,
    input logic       mreset,
    input logic       rdrf,
    input logic       dcd_lat,
    input logic       rd_arm,
    input logic       rx_load
);
    wire data_rd = cs & rw & rs;
    wire ctrl_wr = cs & ~rw & ~rs;

    // R9: interrupt only from an enabled, pending source
    p_irq_src_r9: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (rie && (rdrf || dcd_lat)));

    // R9: control write lands in the register
    p_ctrl_load_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (ctrl == ctrl_t'($past(wdata))));

    // R2: full flag rises only from a completed frame
    p_full_from_load_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(rdrf) |-> $past(rx_load));

    // R5: data read clears the full flag
    p_rdrf_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !rx_load && !mreset) |=> !rdrf);

    // R7: carrier rise captured
    p_dcd_set_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(dcd) && !mreset) |=> dcd_lat);

    // R8: latch holds until the armed data read
    p_lat_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (dcd_lat && !(rd_arm && data_rd) && !mreset) |=> dcd_lat);

    // R10: master reset clears flags
    p_mreset_r10: assert property (@(posedge clk) disable iff (rst)
        mreset |=> (!rdrf && !dcd_lat));

endmodule

bind tape_rx tape_rx_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .cs      (cs),
    .rw      (rw),
    .rs      (rs),
    .wdata   (wdata),
    .dcd     (dcd),
    .irq_n   (irq_n),
    .ctrl    (ctrl),
    .rie     (rie),
    .mreset  (mreset),
    .rdrf    (rdrf),
    .dcd_lat (dcd_lat),
    .rd_arm  (rd_arm),
    .rx_load (rx_load)
);

// File: tb/test_tape_rx.sv
module test_tape_rx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, rw = 1'b1, rs = 1'b0;
    logic       rxd = 1'b1, dcd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_n;
    logic       rx_tick;
    logic [1:0] tdiv = 2'd0;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz
    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign rx_tick = (tdiv == 2'd0);

    tape_rx #(.OVS(16)) i_tape_rx (
        .clk(clk), .rst(rst), .cs(cs), .rw(rw), .rs(rs), .wdata(wdata),
        .rdata(rdata), .irq_n(irq_n), .rx_tick(rx_tick), .rxd(rxd), .dcd(dcd)
    );

    function automatic logic [7:0] exp_status(bit full, bit nocar, bit irq);
        return {irq, 4'b0000, nocar, 1'b0, full};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick_pass();
        do @(negedge clk); while (!rx_tick);
        @(negedge clk);
    endtask

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (16) tick_pass();
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_v);
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(b[i]);
        hold_bit(stop_v);
        hold_bit(1'b1);
    endtask

    task automatic bus_rd(input logic sel, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rw = 1'b1; rs = sel;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic bus_wr(input logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; rw = 1'b0; rs = 1'b0; wdata = v;
        @(negedge clk);
        cs = 1'b0; rw = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] pat [8];
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_rd(1'b0, d);
        check("R1 status", d, exp_status(0, 0, 0));
        check("R1 irq_n", {7'd0, irq_n}, 8'd1);

        // R2/R5/R9 polled reception, directed then random
        pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'hA5;
        for (int i = 3; i < 8; i++) pat[i] = 8'($urandom);
        for (int i = 0; i < 8; i++) begin
            send_frame(pat[i], 1'b1);
            bus_rd(1'b0, d);
            check("R2 status full", d, exp_status(1, 0, 0));
            check("R9 polled irq_n high", {7'd0, irq_n}, 8'd1);
            bus_rd(1'b1, d);
            check("R2 data", d, pat[i]);
            bus_rd(1'b0, d);
            check("R5 full cleared", d, exp_status(0, 0, 0));
        end

        // R3 bad stop bit
        send_frame(8'h3C, 1'b0);
        repeat (32) tick_pass();
        bus_rd(1'b0, d);
        check("R3 framing discard", d, exp_status(0, 0, 0));
        bus_rd(1'b1, d);
        check("R3 data unchanged", d, pat[7]);

        // R4 short false start
        @(negedge clk);
        hold_bit(1'b1);
        rxd = 1'b0;
        repeat (4) tick_pass();
        rxd = 1'b1;
        repeat (48) tick_pass();
        bus_rd(1'b0, d);
        check("R4 false start", d, exp_status(0, 0, 0));

        // R6 overwrite while full
        send_frame(8'h11, 1'b1);
        send_frame(8'h22, 1'b1);
        bus_rd(1'b0, d);
        check("R6 still full", d, exp_status(1, 0, 0));
        bus_rd(1'b1, d);
        check("R6 newest kept", d, 8'h22);

        // R9 receive interrupt
        bus_wr(8'h80);
        send_frame(8'h5A, 1'b1);
        check("R9 irq_n low on rx", {7'd0, irq_n}, 8'd0);
        bus_rd(1'b0, d);
        check("R9 status irq", d, exp_status(1, 0, 1));
        bus_rd(1'b1, d);
        check("R9 data", d, 8'h5A);
        check("R5 irq released", {7'd0, irq_n}, 8'd1);

        // R7/R8 carrier loss latch
        @(negedge clk); dcd = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 irq_n on dcd rise", {7'd0, irq_n}, 8'd0);
        dcd = 1'b0;
        repeat (2) @(negedge clk);
        bus_rd(1'b1, d);  // data read without prior status read
        bus_rd(1'b0, d);
        check("R8 latch survives lone data read", d, exp_status(0, 1, 1));
        check("R7 irq_n held", {7'd0, irq_n}, 8'd0);
        bus_rd(1'b1, d);
        bus_rd(1'b0, d);
        check("R8 latch cleared", d, exp_status(0, 0, 0));
        check("R9 irq_n released", {7'd0, irq_n}, 8'd1);

        // R10 master reset
        bus_wr(8'h00);
        send_frame(8'h77, 1'b1);
        @(negedge clk); dcd = 1'b1;
        repeat (2) @(negedge clk);
        dcd = 1'b0;
        bus_wr(8'h03);
        bus_rd(1'b0, d);
        check("R10 flags cleared", d, exp_status(0, 0, 0));
        send_frame(8'h99, 1'b1);
        bus_rd(1'b0, d);
        check("R10 held idle", d, exp_status(0, 0, 0));
        bus_wr(8'h00);
        send_frame(8'hC3, 1'b1);
        bus_rd(1'b0, d);
        check("R10 resume status", d, exp_status(1, 0, 0));
        bus_rd(1'b1, d);
        check("R10 resume data", d, 8'hC3);

        done = 1'b1;
        finish_run();
    end

endmodule